// File: doc/BRIEF.md
# Side-Set and Delay Field Sequencer

This block sits beside the instruction decoder of a small programmable I/O state machine. Every 16-bit instruction word carries one 5-bit field, and the block splits that field at run time. Part of it drives a few side pins, part of it can be an apply flag, and the rest is a count of extra cycles to wait after the instruction. The split depends on two settings: the number of side pins in use (0, 1 or 2) and whether optional mode is on. The main operation of the instruction (shift, jump, pull and so on) is handled elsewhere.

When the decoder issues an instruction, the block writes the decoded side value to the pins at the clock edge that accepts the issue strobe. The pins then hold that value for the whole instruction, including every delay cycle. At the same time the block loads a delay counter and raises a stall output. The stall keeps the program counter still until the counter runs out. The sequencer has two named states. In RUN, no delay is pending and issues are accepted. In HOLD, the counter is draining and the stall is high. The transition RUN to HOLD happens when an issue is accepted with a non-zero delay. The transition HOLD to RUN happens on the edge where the counter steps down from one. An accepted issue with a zero delay keeps the block in RUN.

Top module: `ssq_sequencer`

## Requirements
- R1: After reset the side pins are 0, the pin-update enable is 0 and the stall is 0.
- R2: The shared field is `instr_word[12:8]`. With zero side pins and optional mode off, all five field bits form the delay (0 to 31), and the pins are not written.
- R3: With one side pin and optional mode off, field bit 4 goes to `side_pins[0]` and field bits 3:0 form the delay (maximum 15).
- R4: With two side pins and optional mode off, field bits 4:3 go to `side_pins[1:0]` and field bits 2:0 form the delay (maximum 7). A setting of 3 behaves as 2.
- R5: In optional mode, field bit 4 is an apply flag. The side bits sit directly below it, and the delay takes the bits that remain. When the flag is 0, the pins keep their values and no update is signalled, but the delay still applies.
- R6: The pins take their new value at the clock edge that accepts the issue. `side_pin_we` is high for exactly the one following cycle when a side value was applied, and low otherwise.
- R7: An accepted issue with delay d holds `fetch_stall` high for exactly d cycles, starting in the cycle after the issue edge. When d is 0, no stall is raised.
- R8: The side pins do not change while a delay is counting down.
- R9: An issue strobe that arrives while the stall is high is ignored. It does not change the pins and does not extend the stall.
- R10: A side pin above the configured count keeps its previous value when another instruction writes the lower pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_word | input | 16 | Fetched instruction word |
| instr_issue | input | 1 | Strobe: the instruction is issued in this cycle |
| side_count | input | 2 | Number of side pins in use (0 to 2; 3 behaves as 2) |
| side_opt | input | 1 | Optional mode: field MSB is an apply flag |
| side_pins | output | 2 | Side pin values |
| side_pin_we | output | 1 | Pin-update enable, one cycle per applied side value |
| fetch_stall | output | 1 | Holds the program counter during delay cycles |

## Verification
The bench builds the block with its default parameters: a 5-bit field at bits 12:8 and two side pins. With these values every split of the field can be reached, from a 5-bit delay with no pins up to two pins plus an apply flag, including the largest delay of 31 cycles. The bench counts the stall length of each instruction and compares it with the decoded delay. It also checks that the pins hold during the delay, that an upper pin is left alone when only the lower pin is configured, and that issue strobes arriving during a stall are ignored.

// File: rtl/ssq_pkg.sv
package ssq_pkg;
    localparam int SSQ_FIELD_W = 5;
    localparam int SSQ_MAX_SS  = 2;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_HOLD = 1'b1
    } ssq_state_t;
endpackage

// File: rtl/ssq_field_decode.sv
module ssq_field_decode #(
    parameter int FIELD_W = ssq_pkg::SSQ_FIELD_W,
    parameter int MAX_SS  = ssq_pkg::SSQ_MAX_SS,
    localparam int CW     = $clog2(MAX_SS + 1)
) (
    input  logic [FIELD_W-1:0] field,
    input  logic [CW-1:0]      ss_cfg,
    input  logic               opt_en,
    output logic               apply,
    output logic [MAX_SS-1:0]  side_val,
    output logic [MAX_SS-1:0]  side_mask,
    output logic [FIELD_W-1:0] delay
);
    localparam int UW = $clog2(FIELD_W + 1);

    logic [UW-1:0]      ss_eff;
    logic [UW-1:0]      used;
    logic [UW-1:0]      dly_bits;
    logic [FIELD_W-1:0] upper;

    always_comb begin
        if (UW'(ss_cfg) > UW'(MAX_SS)) ss_eff = UW'(MAX_SS);
        else                           ss_eff = UW'(ss_cfg);
        used     = ss_eff + UW'(opt_en);
        dly_bits = UW'(FIELD_W) - used;
        upper    = field >> dly_bits;
    end

    always_comb begin
        for (int i = 0; i < FIELD_W; i++) begin
            delay[i] = (i < int'(dly_bits)) ? field[i] : 1'b0;
        end
        for (int j = 0; j < MAX_SS; j++) begin
            side_mask[j] = (j < int'(ss_eff));
            side_val[j]  = side_mask[j] ? upper[j] : 1'b0;
        end
        apply = (ss_eff != '0) && (!opt_en || field[FIELD_W-1]);
    end
endmodule

// File: rtl/ssq_delay_fsm.sv
module ssq_delay_fsm #(
    parameter int FIELD_W = ssq_pkg::SSQ_FIELD_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               accept,
    input  logic [FIELD_W-1:0] load_val,
    output logic               stall,
    output logic [FIELD_W-1:0] count
);
    import ssq_pkg::*;

    ssq_state_t         state_q, state_d;
    logic [FIELD_W-1:0] count_d;

    always_comb begin
        state_d = state_q;
        count_d = count;
        unique case (state_q)
            ST_RUN: begin
                if (accept && load_val != '0) begin
                    state_d = ST_HOLD;
                    count_d = load_val;
                end
            end
            ST_HOLD: begin
                count_d = count - FIELD_W'(1);
                if (count == FIELD_W'(1)) state_d = ST_RUN;
            end
            default: state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            count   <= '0;
        end else begin
            state_q <= state_d;
            count   <= count_d;
        end
    end

    always_comb begin
        stall = (state_q == ST_HOLD);
    end
endmodule

// File: rtl/ssq_pin_bank.sv
module ssq_pin_bank #(
    parameter int MAX_SS = ssq_pkg::SSQ_MAX_SS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              apply,
    input  logic [MAX_SS-1:0] side_val,
    input  logic [MAX_SS-1:0] side_mask,
    output logic [MAX_SS-1:0] pins,
    output logic              pin_we
);
    for (genvar g = 0; g < MAX_SS; g++) begin : g_pin
        always_ff @(posedge clk) begin
            if (!rst_n)                             pins[g] <= 1'b0;
            else if (accept && apply && side_mask[g]) pins[g] <= side_val[g];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pin_we <= 1'b0;
        else        pin_we <= accept && apply;
    end
endmodule

// File: rtl/ssq_sequencer.sv
module ssq_sequencer #(
    parameter int INSTR_W   = 16,
    parameter int FIELD_LSB = 8,
    parameter int FIELD_W   = ssq_pkg::SSQ_FIELD_W,
    parameter int MAX_SS    = ssq_pkg::SSQ_MAX_SS,
    localparam int CW       = $clog2(MAX_SS + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INSTR_W-1:0] instr_word,
    input  logic               instr_issue,
    input  logic [CW-1:0]      side_count,
    input  logic               side_opt,
    output logic [MAX_SS-1:0]  side_pins,
    output logic               side_pin_we,
    output logic               fetch_stall
);
    logic [FIELD_W-1:0] field;
    logic               accept;
    logic               dec_apply;
    logic [MAX_SS-1:0]  dec_side;
    logic [MAX_SS-1:0]  dec_mask;
    logic [FIELD_W-1:0] dec_delay;
    logic [FIELD_W-1:0] hold_cnt;

    always_comb begin
        field  = instr_word[FIELD_LSB +: FIELD_W];
        accept = instr_issue && !fetch_stall;
    end

    ssq_field_decode #(.FIELD_W(FIELD_W), .MAX_SS(MAX_SS)) u_dec (
        .field    (field),
        .ss_cfg   (side_count),
        .opt_en   (side_opt),
        .apply    (dec_apply),
        .side_val (dec_side),
        .side_mask(dec_mask),
        .delay    (dec_delay)
    );

    ssq_delay_fsm #(.FIELD_W(FIELD_W)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .accept  (accept),
        .load_val(dec_delay),
        .stall   (fetch_stall),
        .count   (hold_cnt)
    );

    ssq_pin_bank #(.MAX_SS(MAX_SS)) u_pins (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .apply    (dec_apply),
        .side_val (dec_side),
        .side_mask(dec_mask),
        .pins     (side_pins),
        .pin_we   (side_pin_we)
    );
endmodule

// File: rtl/ssq_sequencer_chk.sv
module ssq_sequencer_chk #(
    parameter int FIELD_W = ssq_pkg::SSQ_FIELD_W,
    parameter int MAX_SS  = ssq_pkg::SSQ_MAX_SS
) (
    input logic               clk,
    input logic               rst_n,
    input logic               accept,
    input logic [FIELD_W-1:0] dec_delay,
    input logic [FIELD_W-1:0] hold_cnt,
    input logic [MAX_SS-1:0]  side_pins,
    input logic               side_pin_we,
    input logic               fetch_stall
);
    // R7: a non-zero delay starts a stall loaded with that delay
    p_stall_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && dec_delay != '0) |=> (fetch_stall && hold_cnt == $past(dec_delay)));

    // R7: a zero delay raises no stall
    p_no_stall_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && dec_delay == '0) |=> !fetch_stall);

    // R7: the stall continues while more than one cycle is left
    p_stall_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_stall && hold_cnt != FIELD_W'(1)) |=> fetch_stall);

    // R7: the stall ends after the last cycle
    p_stall_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_stall && hold_cnt == FIELD_W'(1)) |=> !fetch_stall);

    // R6: an update pulse only follows an accepted issue
    p_we_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
        side_pin_we |-> $past(accept));

    // R5: pins move only together with an update pulse
    p_pins_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !side_pin_we |-> $stable(side_pins));

    // R8: pins hold through delay cycles
    p_pins_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_stall && $past(fetch_stall)) |-> $stable(side_pins));
endmodule

bind ssq_sequencer ssq_sequencer_chk #(.FIELD_W(FIELD_W), .MAX_SS(MAX_SS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .dec_delay  (dec_delay),
    .hold_cnt   (hold_cnt),
    .side_pins  (side_pins),
    .side_pin_we(side_pin_we),
    .fetch_stall(fetch_stall)
);

// File: tb/ssq_sequencer_tb.sv
module ssq_sequencer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] instr_word = '0;
    logic        instr_issue = 1'b0;
    logic [1:0]  side_count = '0;
    logic        side_opt = 1'b0;
    logic [1:0]  side_pins;
    logic        side_pin_we;
    logic        fetch_stall;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    ssq_sequencer u_dut (
        .clk(clk), .rst_n(rst_n), .instr_word(instr_word), .instr_issue(instr_issue),
        .side_count(side_count), .side_opt(side_opt), .side_pins(side_pins),
        .side_pin_we(side_pin_we), .fetch_stall(fetch_stall)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Issue one instruction and follow it through all of its delay cycles.
    task automatic run_instr(input string req, input logic [4:0] fld, input logic [1:0] cnt,
                             input logic opt, input int exp_pins, input int exp_we,
                             input int exp_delay);
        int stalls;
        int held;
        @(negedge clk);
        side_count  = cnt;
        side_opt    = opt;
        instr_word  = {3'b101, fld, 8'h5C};
        instr_issue = 1'b1;
        @(negedge clk);
        instr_issue = 1'b0;
        instr_word  = 16'hFFFF;
        check(req, "pins after issue", int'(side_pins), exp_pins);
        check(req, "update pulse", int'(side_pin_we), exp_we);
        stalls = 0;
        held   = 1;
        while (fetch_stall && stalls < 40) begin
            stalls++;
            @(negedge clk);
            if (int'(side_pins) != exp_pins || side_pin_we) held = 0;
        end
        check(req, "stall cycles", stalls, exp_delay);
        check("R8", "pins held through delay", held, 1);
    endtask

    task automatic t_reset();
        check("R1", "reset pins", int'(side_pins), 0);
        check("R1", "reset update", int'(side_pin_we), 0);
        check("R1", "reset stall", int'(fetch_stall), 0);
    endtask

    task automatic t_no_side();
        run_instr("R2", 5'b00101, 2'd0, 1'b0, 0, 0, 5);
        run_instr("R2", 5'b11111, 2'd0, 1'b0, 0, 0, 31);
    endtask

    task automatic t_one_side();
        run_instr("R3", 5'b10011, 2'd1, 1'b0, 1, 1, 3);
        run_instr("R3", 5'b01111, 2'd1, 1'b0, 0, 1, 15);
        run_instr("R7", 5'b10000, 2'd1, 1'b0, 1, 1, 0);
    endtask

    task automatic t_two_side();
        run_instr("R4", 5'b10101, 2'd2, 1'b0, 2, 1, 5);
        run_instr("R4", 5'b01111, 2'd2, 1'b0, 1, 1, 7);
        run_instr("R4", 5'b11010, 2'd3, 1'b0, 3, 1, 2);
    endtask

    task automatic t_upper_kept();
        run_instr("R10", 5'b11001, 2'd2, 1'b0, 3, 1, 1);
        run_instr("R10", 5'b00010, 2'd1, 1'b0, 2, 1, 2);
    endtask

    task automatic t_optional();
        run_instr("R5", 5'b00000, 2'd2, 1'b0, 0, 1, 0);
        run_instr("R5", 5'b11010, 2'd1, 1'b1, 1, 1, 2);
        run_instr("R5", 5'b01010, 2'd1, 1'b1, 1, 0, 2);
        run_instr("R5", 5'b10110, 2'd2, 1'b1, 1, 1, 2);
        run_instr("R5", 5'b10111, 2'd0, 1'b1, 1, 0, 7);
    endtask

    task automatic t_issue_in_stall();
        int stalls;
        @(negedge clk);
        side_count  = 2'd2;
        side_opt    = 1'b0;
        instr_word  = {3'b000, 5'b01100, 8'h00};
        instr_issue = 1'b1;
        @(negedge clk);
        instr_word  = {3'b000, 5'b10111, 8'h00};
        check("R6", "pins at issue edge", int'(side_pins), 1);
        stalls = 0;
        while (fetch_stall && stalls < 40) begin
            stalls++;
            @(negedge clk);
        end
        instr_issue = 1'b0;
        check("R9", "stall not extended", stalls, 4);
        check("R9", "pins not rewritten", int'(side_pins), 1);
        @(negedge clk);
        check("R9", "no later update", int'(side_pin_we), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_reset();
        t_no_side();
        t_one_side();
        t_two_side();
        t_upper_kept();
        t_optional();
        t_issue_in_stall();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule